// File: doc/BRIEF.md
# Daisy-Chain Response Word Receiver

This block sits on the receive side of a slow serial daisy chain that links a host interface to a string of remote units. Each response word travels as three asynchronous characters. The block samples the serial line, checks each character's parity, stop bits and word-position flag, and joins the three 6-bit payloads into an 18-bit value. It then offers the lower 16 bits to a readout buffer on a valid/ready handshake.

The two upper bits of each assembled value are attention bits. The top bit sets a sticky high-priority flag, used for failures. The next bit sets a sticky low-priority flag, used for "transfer finished" notices. The low-priority output can be held off by an external active-low disable pin; the underlying flag still records the event. A third sticky flag reports transmission faults: parity, framing, stop bit, or a character that arrives while a finished word is still waiting to be taken. A clear input or reset drops all three flags.

Two state machines do the work. The character machine has the states C_IDLE, C_START, C_BITS and C_DONE. It moves C_IDLE→C_START on a low line. It moves C_START→C_BITS if the line is still low at half a bit time, and C_START→C_IDLE if it is not. It moves C_BITS→C_DONE after the last stop-bit sample, and C_DONE→C_IDLE on the next cycle. The word machine has the states W_FIRST, W_SECOND, W_THIRD and W_HOLD. It steps W_FIRST→W_SECOND→W_THIRD→W_HOLD on good characters and returns W_HOLD→W_FIRST on a handshake. A bad character sends any state back to W_FIRST. A character with the flag set restarts in W_SECOND from any state.

Top module: `resp_chain_rx`

## Requirements
- R1: The line idles high. A character is a low start bit, then 6 payload bits least significant first, then a flag bit, a parity bit and two stop bits, each CLKS_PER_BIT clocks long.
- R2: The first character of a word supplies assembled bits 17:12, the second bits 11:6 and the third bits 5:0. word_data carries bits 15:0.
- R3: word_valid rises only after a third good character. It stays high with word_data unchanged until a cycle with word_ready high.
- R4: Parity is odd over the 6 payload bits, the flag bit and the parity bit. A failing character sets rx_error and drops the partial word.
- R5: The flag bit is 1 in the first character and 0 in the others. A flag-0 character where a first character is due sets rx_error. A flag-1 character in mid-word sets rx_error and starts a new word with that character.
- R6: A low first stop bit sets rx_error and drops the partial word.
- R7: A character that completes while word_valid is high and word_ready is low sets rx_error. The held word is left unchanged.
- R8: Assembled bit 17 set raises irq_hi and bit 16 set raises the low-priority flag. Words with these bits at 0 never lower either flag.
- R9: irq_lo is low while lo_disable_n is low. The low-priority flag is kept and shows once lo_disable_n returns high.
- R10: A flags_clr pulse lowers irq_hi, the low-priority flag and rx_error on the next clock.
- R11: After reset, word_valid, irq_hi, irq_lo and rx_error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line from the chain, idle high |
| lo_disable_n | input | 1 | Low holds off irq_lo |
| flags_clr | input | 1 | Clears the three sticky flags |
| word_ready | input | 1 | Readout buffer accepts the word |
| word_data | output | 16 | Assembled data bits |
| word_valid | output | 1 | Word waiting for the readout buffer |
| irq_hi | output | 1 | High-priority attention flag |
| irq_lo | output | 1 | Low-priority attention, gated by lo_disable_n |
| rx_error | output | 1 | Sticky transmission fault |

## Verification
The assertions assume three things about the inputs. The serial line holds each bit for a full CLKS_PER_BIT period. Stop bits are followed by idle-high time before the next start. flags_clr and word_ready are plain synchronous levels. The bench drives the line only through a task that times every bit to CLKS_PER_BIT and leaves a short idle gap after each character. Random words use random attention bits, random disable levels and random readout delays. Faulty characters appear only in the directed parity, flag, stop-bit and overrun cases.

// File: rtl/resp_rx_pkg.sv
package resp_rx_pkg;
    localparam int CHAR_W     = 6;
    localparam int NUM_CHARS  = 3;
    localparam int WORD_W     = CHAR_W * NUM_CHARS;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = CHAR_W + 4;   // payload, flag, parity, two stops
    localparam int NUM_FLAGS  = 3;
    localparam int FLAG_HI    = 0;
    localparam int FLAG_LO    = 1;
    localparam int FLAG_ERR   = 2;

    typedef enum logic [1:0] {C_IDLE, C_START, C_BITS, C_DONE} crx_state_t;
    typedef enum logic [1:0] {W_FIRST, W_SECOND, W_THIRD, W_HOLD} asm_state_t;

    typedef struct packed {
        logic [CHAR_W-1:0] payload;
        logic              flag;
        logic              par_ok;
        logic              stop_ok;
    } rx_char_t;
endpackage

// File: rtl/resp_char_rx.sv
module resp_char_rx
    import resp_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 83333
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_line,
    output logic     char_valid,
    output rx_char_t char_out
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1  = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [1:0]            sync_q;
    logic                  rx_s;
    crx_state_t            state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic                  bit_tick;

    assign rx_s     = sync_q[1];
    assign bit_tick = (state_q == C_BITS) && (cnt_q == FULL_M1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:  if (!rx_s) state_d = C_START;
            C_START: if (cnt_q == HALF_M1) state_d = rx_s ? C_IDLE : C_BITS;
            C_BITS:  if (bit_tick && idx_q == LAST_IDX) state_d = C_DONE;
            C_DONE:  state_d = C_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    // bit timing and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else begin
            unique case (state_q)
                C_IDLE, C_DONE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
                C_START: cnt_q <= (cnt_q == HALF_M1) ? '0 : cnt_q + 1'b1;
                C_BITS: begin
                    cnt_q <= bit_tick ? '0 : cnt_q + 1'b1;
                    if (bit_tick) begin
                        sh_q[idx_q] <= rx_s;
                        idx_q       <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        char_valid       = (state_q == C_DONE);
        char_out.payload = sh_q[CHAR_W-1:0];
        char_out.flag    = sh_q[CHAR_W];
        char_out.par_ok  = ^sh_q[CHAR_W+1:0];
        char_out.stop_ok = &sh_q[FRAME_BITS-1:CHAR_W+2];
    end

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);
endmodule

// File: rtl/resp_word_asm.sv
module resp_word_asm
    import resp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  rx_char_t          ch,
    input  logic              word_ready,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              set_hi,
    output logic              set_lo,
    output logic              set_err
);
    asm_state_t        state_q, state_d, base;
    logic [CHAR_W-1:0] hi_q, mid_q;
    logic [DATA_W-1:0] word_q;
    logic              load_hi, load_mid, complete, released;

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        load_hi  = 1'b0;
        load_mid = 1'b0;
        complete = 1'b0;
        set_err  = 1'b0;
        released = (state_q == W_HOLD) && word_ready;
        base     = released ? W_FIRST : state_q;
        if (state_q == W_HOLD && !word_ready) begin
            if (char_valid) set_err = 1'b1;
        end else begin
            state_d = base;
            if (char_valid) begin
                if (!(ch.par_ok && ch.stop_ok)) begin
                    set_err = 1'b1;
                    state_d = W_FIRST;
                end else if (ch.flag) begin
                    load_hi = 1'b1;
                    state_d = W_SECOND;
                    if (base != W_FIRST) set_err = 1'b1;
                end else begin
                    unique case (base)
                        W_FIRST:  set_err = 1'b1;
                        W_SECOND: begin load_mid = 1'b1; state_d = W_THIRD; end
                        W_THIRD:  begin complete = 1'b1; state_d = W_HOLD;  end
                        default:  ;
                    endcase
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_FIRST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            mid_q  <= '0;
            word_q <= '0;
        end else begin
            if (load_hi)  hi_q  <= ch.payload;
            if (load_mid) mid_q <= ch.payload;
            if (complete) word_q <= {hi_q[CHAR_W-3:0], mid_q, ch.payload};
        end
    end

    // outputs
    always_comb begin
        word_valid = (state_q == W_HOLD);
        word_data  = word_q;
        set_hi     = complete && hi_q[CHAR_W-1];
        set_lo     = complete && hi_q[CHAR_W-2];
    end

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    a_r3_rise_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(char_valid));
endmodule

// File: rtl/resp_irq_flags.sv
module resp_irq_flags
    import resp_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic                 clr,
    input  logic                 lo_disable_n,
    output logic                 irq_hi,
    output logic                 irq_lo,
    output logic                 rx_error
);
    logic [NUM_FLAGS-1:0] flag_q;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[g] <= 1'b0;
            else if (set_vec[g]) flag_q[g] <= 1'b1;
            else if (clr)        flag_q[g] <= 1'b0;
        end

        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr) |=> flag_q[g]);

        a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set_vec[g]) |=> !flag_q[g]);
    end

    assign irq_hi   = flag_q[FLAG_HI];
    assign irq_lo   = flag_q[FLAG_LO] && lo_disable_n;
    assign rx_error = flag_q[FLAG_ERR];
endmodule

// File: rtl/resp_chain_rx.sv
module resp_chain_rx
    import resp_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 83333
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_line,
    input  logic        lo_disable_n,
    input  logic        flags_clr,
    input  logic        word_ready,
    output logic [15:0] word_data,
    output logic        word_valid,
    output logic        irq_hi,
    output logic        irq_lo,
    output logic        rx_error
);
    logic                 char_valid;
    rx_char_t             ch;
    logic                 set_hi, set_lo, set_err;
    logic [NUM_FLAGS-1:0] set_vec;

    resp_char_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_char (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .char_valid (char_valid),
        .char_out   (ch)
    );

    resp_word_asm u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_valid (char_valid),
        .ch         (ch),
        .word_ready (word_ready),
        .word_data  (word_data),
        .word_valid (word_valid),
        .set_hi     (set_hi),
        .set_lo     (set_lo),
        .set_err    (set_err)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_HI]  = set_hi;
        set_vec[FLAG_LO]  = set_lo;
        set_vec[FLAG_ERR] = set_err;
    end

    resp_irq_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_vec      (set_vec),
        .clr          (flags_clr),
        .lo_disable_n (lo_disable_n),
        .irq_hi       (irq_hi),
        .irq_lo       (irq_lo),
        .rx_error     (rx_error)
    );

    a_r7_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready && char_valid) |=> (rx_error && word_valid));
endmodule

// File: tb/tb_resp_chain_rx.sv
`timescale 1ns/1ps
module tb_resp_chain_rx;
    localparam int CPB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        lo_disable_n = 1'b1;
    logic        flags_clr = 1'b0;
    logic        word_ready = 1'b0;
    logic [15:0] word_data;
    logic        word_valid, irq_hi, irq_lo, rx_error;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    resp_chain_rx #(.CLKS_PER_BIT(CPB)) dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .lo_disable_n(lo_disable_n),
        .flags_clr(flags_clr), .word_ready(word_ready), .word_data(word_data),
        .word_valid(word_valid), .irq_hi(irq_hi), .irq_lo(irq_lo), .rx_error(rx_error)
    );

    function automatic logic odd_par(input logic [5:0] p, input logic f);
        return ~^{f, p};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [5:0] p, input logic f, input logic bad_par,
                             input logic bad_stop);
        logic [9:0] fr;
        fr = {1'b1, ~bad_stop, odd_par(p, f) ^ bad_par, f, p};
        @(negedge clk) rx_line = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            rx_line = fr[i];
            repeat (CPB) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [17:0] w);
        send_char(w[17:12], 1'b1, 1'b0, 1'b0);
        send_char(w[11:6],  1'b0, 1'b0, 1'b0);
        send_char(w[5:0],   1'b0, 1'b0, 1'b0);
    endtask

    task automatic accept();
        word_ready = 1'b1;
        @(negedge clk) word_ready = 1'b0;
    endtask

    task automatic pulse_clr();
        flags_clr = 1'b1;
        @(negedge clk) flags_clr = 1'b0;
    endtask

    initial begin
        logic [17:0] w;
        logic        exp_hi, exp_lo, dis;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 valid", word_valid, 0);
        chk("R11 irq_hi", irq_hi, 0);
        chk("R11 irq_lo", irq_lo, 0);
        chk("R11 err", rx_error, 0);

        // R1 R2 R3 directed word
        send_word(18'h0ABCD);
        chk("R1 R2 data", word_data, 16'hABCD);
        chk("R3 valid", word_valid, 1);
        repeat (25) @(negedge clk);
        chk("R3 held valid", word_valid, 1);
        chk("R3 held data", word_data, 16'hABCD);
        accept();
        chk("R3 released", word_valid, 0);
        chk("R8 zero bits", {irq_hi, rx_error}, 0);

        // random words: R2 R8 R9 R10
        exp_hi = 0; exp_lo = 0;
        for (int k = 0; k < 30; k++) begin
            w   = 18'($urandom);
            dis = 1'($urandom);
            lo_disable_n = dis;
            send_word(w);
            exp_hi |= w[17];
            exp_lo |= w[16];
            chk("R2 random data", word_data, {16'h0, w[15:0]});
            chk("R3 random valid", word_valid, 1);
            chk("R8 irq_hi", irq_hi, exp_hi);
            chk("R9 irq_lo", irq_lo, exp_lo & dis);
            chk("R4 no error", rx_error, 0);
            repeat ($urandom % 20) @(negedge clk);
            accept();
            if ($urandom % 5 == 0) begin
                pulse_clr();
                exp_hi = 0; exp_lo = 0;
                lo_disable_n = 1'b1;
                @(negedge clk);
                chk("R10 cleared", {irq_hi, irq_lo}, 0);
            end
        end
        pulse_clr();
        lo_disable_n = 1'b1;

        // R4 parity failure mid-word
        send_char(6'h21, 1'b1, 1'b0, 1'b0);
        send_char(6'h05, 1'b0, 1'b1, 1'b0);
        chk("R4 parity err", rx_error, 1);
        chk("R4 no word", word_valid, 0);
        send_char(6'h07, 1'b0, 1'b0, 1'b0);
        chk("R4 dropped", word_valid, 0);
        pulse_clr();
        chk("R10 err cleared", rx_error, 0);
        send_word(18'h01234);
        chk("R4 recover data", word_data, 16'h1234);
        chk("R4 recover err", rx_error, 0);
        accept();

        // R5 flag rule
        send_char(6'h15, 1'b0, 1'b0, 1'b0);
        chk("R5 flag0 first", rx_error, 1);
        chk("R5 no word", word_valid, 0);
        pulse_clr();
        send_char(6'h3F, 1'b1, 1'b0, 1'b0);
        send_char(6'h2A, 1'b1, 1'b0, 1'b0);
        chk("R5 restart err", rx_error, 1);
        send_char(6'h11, 1'b0, 1'b0, 1'b0);
        send_char(6'h22, 1'b0, 1'b0, 1'b0);
        chk("R5 restart valid", word_valid, 1);
        chk("R5 restart data", word_data, {4'hA, 6'h11, 6'h22});
        chk("R8 restart hi", irq_hi, 1);
        accept();
        pulse_clr();

        // R6 bad stop bit
        send_char(6'h30, 1'b1, 1'b0, 1'b1);
        send_char(6'h01, 1'b0, 1'b0, 1'b0);
        send_char(6'h02, 1'b0, 1'b0, 1'b0);
        chk("R6 stop err", rx_error, 1);
        chk("R6 no word", word_valid, 0);
        pulse_clr();

        // R7 overrun
        send_word(18'h05A5A);
        chk("R7 pre err", rx_error, 0);
        send_char(6'h0C, 1'b1, 1'b0, 1'b0);
        chk("R7 overrun err", rx_error, 1);
        chk("R7 held valid", word_valid, 1);
        chk("R7 held data", word_data, 16'h5A5A);
        accept();
        chk("R7 released", word_valid, 0);
        pulse_clr();

        // R9 masking, R8 stickiness, R10 clear
        lo_disable_n = 1'b0;
        send_word(18'h1_0F0F);
        chk("R9 masked", irq_lo, 0);
        chk("R8 hi untouched", irq_hi, 0);
        accept();
        lo_disable_n = 1'b1;
        @(negedge clk);
        chk("R9 unmasked", irq_lo, 1);
        send_word(18'h0_0001);
        chk("R8 lo sticky", irq_lo, 1);
        accept();
        pulse_clr();
        chk("R10 lo cleared", irq_lo, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule